// File: doc/BRIEF.md
# Addressed I2C Target Port

This block is an I2C target (slave) port. It answers to one programmable 7-bit address and moves data one byte at a time. A host processor serves the port through single-byte receive and transmit buffers. The bus side watches SCL and SDA through synchronizers and finds START and STOP conditions. It compares the address byte against the programmed value and acknowledges a match. It then shifts data bytes in or out. SDA and SCL are only ever pulled low, through open-drain enable outputs.

The processor writes a configuration byte: bit 7 is the enable and bits 6 to 0 are the address. It reads received bytes, pulsing `rx_rd_i` to free the buffer. It writes bytes to send with `tx_we_i`. Two flags tell it when to act. `rx_full_o` means a byte is waiting. `tx_need_o` means the transmit side wants a new byte. If the processor falls behind, the port holds SCL low until the relevant buffer has been serviced, so no byte is lost or invented.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o`, `rx_full_o`, `tx_need_o`, `nack_o` and `match_evt_o` are all 0.
- R2: Configuration byte bit 7 = 1 enables the port and bits 6..0 give its address. While bit 7 = 0, the port never drives SCL or SDA, never acknowledges, and `busy_o` stays 0.
- R3: `busy_o` rises when an enabled port sees a START, falls on a STOP, and is 1 whenever the port drives SCL or SDA.
- R4: When bits 7..1 of the first byte after a START equal the address, SDA is driven low during the ninth clock (ACK) and `match_evt_o` pulses for exactly one cycle. On a mismatch, there is no ACK and the rest of the transfer is ignored, with `rx_full_o` left unchanged.
- R5: `dir_tx_o` takes bit 0 of the last matching address byte (1 = the port transmits, 0 = the port receives).
- R6: In a receive transfer, each data byte, sent MSB first, appears on `rx_data_o` with `rx_full_o` = 1 and is acknowledged. A one-cycle `rx_rd_i` clears `rx_full_o`, and `rx_full_o` never clears without it.
- R7: If `rx_full_o` is still 1 when the next data byte completes, SCL is held low until `rx_rd_i` arrives. The new byte is then delivered and acknowledged, and the older byte stays on `rx_data_o` until that read.
- R8: In a transmit transfer, the buffered byte is shifted out MSB first. `tx_need_o` sets when the port takes a byte from the buffer or finds it empty, and a `tx_we_i` clears it in the next cycle.
- R9: If the transmit buffer is empty when a byte is due, SCL is held low until `tx_we_i` supplies one.
- R10: A master NACK (SDA high on the ninth clock) after a transmitted byte sets `nack_o` and stops the port driving SDA until the next START. `nack_o` clears on the next address match.
- R11: A START repeated without a STOP restarts address decoding, so the direction can change within one bus ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cfg_we_i | input | 1 | Write strobe for the configuration byte |
| cfg_wdata_i | input | 8 | Bit 7 enable, bits 6..0 address |
| rx_rd_i | input | 1 | Receive buffer read strobe |
| rx_data_o | output | 8 | Receive buffer contents |
| rx_full_o | output | 1 | Received byte waiting |
| tx_we_i | input | 1 | Transmit buffer write strobe |
| tx_wdata_i | input | 8 | Byte to transmit |
| tx_need_o | output | 1 | Transmit side wants a new byte |
| match_evt_o | output | 1 | One-cycle pulse on address match |
| busy_o | output | 1 | Bus activity between START and STOP |
| dir_tx_o | output | 1 | 1 = port transmits, 0 = port receives |
| nack_o | output | 1 | Master answered NACK to a sent byte |

## Verification
The bench builds the port with the default two synchronizer stages. It runs a bus master whose quarter bit period is ten clocks. This leaves enough slack for the synchronizer and edge-detect latency, so stretch, ACK and data timing can be checked at the pins. The master honours clock stretching, which lets directed cases hold back the processor and watch SCL being held in both directions. Random transfers mix matching and foreign addresses, read and write directions and lengths of one to three bytes. Each random transfer is compared against a bench model of the address compare and the buffers.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int CNT_W   = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] BIT_END = CNT_W'(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_HOLD,
    ST_RX_ACK,
    ST_TX_LOAD,
    ST_TX,
    ST_TX_ACK
  } slv_state_e;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_q;
      sda_d    <= sda_q;
    end
  end

  assign scl_q      = scl_pipe[STAGES-1];
  assign sda_q      = sda_pipe[STAGES-1];
  assign sda_o      = sda_q;
  assign scl_rise_o = scl_q & ~scl_d;
  assign scl_fall_o = ~scl_q & scl_d;
  // SDA edge with SCL high on both samples
  assign start_o    = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_o     = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_slv_bufs.sv
module i2c_slv_bufs
  import i2c_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  output logic              slv_en_o,
  output logic [ADDR_W-1:0] slv_addr_o,
  input  logic              rx_push_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              rx_rd_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_full_o,
  input  logic              tx_we_i,
  input  logic [BYTE_W-1:0] tx_wdata_i,
  input  logic              tx_pop_i,
  input  logic              tx_stall_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_full_o,
  output logic              tx_need_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slv_en_o   <= 1'b0;
      slv_addr_o <= '0;
    end else if (cfg_we_i) begin
      slv_en_o   <= cfg_wdata_i[BYTE_W-1];
      slv_addr_o <= cfg_wdata_i[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o <= '0;
      rx_full_o <= 1'b0;
    end else if (rx_push_i) begin
      rx_data_o <= rx_byte_i;
      rx_full_o <= 1'b1;
    end else if (rx_rd_i) begin
      rx_full_o <= 1'b0;
    end
  end

  // a write in the same cycle as a pop refills the buffer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_o <= '0;
      tx_full_o <= 1'b0;
      tx_need_o <= 1'b0;
    end else begin
      if (tx_we_i) begin
        tx_data_o <= tx_wdata_i;
        tx_full_o <= 1'b1;
      end else if (tx_pop_i) begin
        tx_full_o <= 1'b0;
      end
      if (tx_we_i)                    tx_need_o <= 1'b0;
      else if (tx_pop_i || tx_stall_i) tx_need_o <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
  import i2c_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slv_en_i,
  input  logic [ADDR_W-1:0] slv_addr_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rx_full_i,
  input  logic              tx_full_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              tx_pop_o,
  output logic              tx_stall_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  output logic              busy_o,
  output logic              dir_tx_o,
  output logic              nack_o,
  output logic              match_o
);
  slv_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic sda_drv_q, busy_q, dir_q, nack_q, match_q;
  logic byte_end, bus_evt;

  assign byte_end   = scl_fall_i && (cnt_q == BIT_END);
  assign bus_evt    = start_i | stop_i;
  assign rx_push_o  = slv_en_i && !bus_evt && !rx_full_i &&
                      ((state_q == ST_RX && byte_end) || state_q == ST_RX_HOLD);
  assign rx_byte_o  = sh_q;
  assign tx_pop_o   = slv_en_i && !bus_evt && state_q == ST_TX_LOAD && tx_full_i;
  assign tx_stall_o = slv_en_i && state_q == ST_TX_LOAD && !tx_full_i;
  assign scl_oe_o   = (state_q == ST_RX_HOLD) || (state_q == ST_TX_LOAD);
  assign sda_oe_o   = sda_drv_q;
  assign busy_o     = busy_q;
  assign dir_tx_o   = dir_q;
  assign nack_o     = nack_q;
  assign match_o    = match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      sda_drv_q <= 1'b0;
      busy_q    <= 1'b0;
      dir_q     <= 1'b0;
      nack_q    <= 1'b0;
      match_q   <= 1'b0;
    end else begin
      match_q <= 1'b0;
      if (!slv_en_i) begin
        state_q   <= ST_IDLE;
        sda_drv_q <= 1'b0;
        busy_q    <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_ADDR;
        cnt_q     <= '0;
        sda_drv_q <= 1'b0;
        busy_q    <= 1'b1;
      end else if (stop_i) begin
        state_q   <= ST_IDLE;
        sda_drv_q <= 1'b0;
        busy_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_end) begin
              if (sh_q[BYTE_W-1:1] == slv_addr_i) begin
                match_q   <= 1'b1;
                dir_q     <= sh_q[0];
                nack_q    <= 1'b0;
                sda_drv_q <= 1'b1;
                state_q   <= ST_ADDR_ACK;
              end else begin
                state_q   <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            sda_drv_q <= 1'b0;
            cnt_q     <= '0;
            state_q   <= dir_q ? ST_TX_LOAD : ST_RX;
          end
          ST_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_end) begin
              if (rx_full_i) state_q <= ST_RX_HOLD;
              else begin
                sda_drv_q <= 1'b1;
                state_q   <= ST_RX_ACK;
              end
            end
          end
          ST_RX_HOLD: if (!rx_full_i) begin
            sda_drv_q <= 1'b1;
            state_q   <= ST_RX_ACK;
          end
          ST_RX_ACK: if (scl_fall_i) begin
            sda_drv_q <= 1'b0;
            cnt_q     <= '0;
            state_q   <= ST_RX;
          end
          ST_TX_LOAD: if (tx_full_i) begin
            sh_q      <= tx_data_i;
            sda_drv_q <= ~tx_data_i[BYTE_W-1];
            cnt_q     <= '0;
            state_q   <= ST_TX;
          end
          ST_TX: begin
            if (scl_rise_i) cnt_q <= cnt_q + 1'b1;
            else if (scl_fall_i) begin
              if (cnt_q == BIT_END) begin
                sda_drv_q <= 1'b0;
                state_q   <= ST_TX_ACK;
              end else begin
                sh_q      <= {sh_q[BYTE_W-2:0], 1'b0};
                sda_drv_q <= ~sh_q[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) nack_q <= sda_i;
            else if (scl_fall_i) state_q <= nack_q ? ST_IDLE : ST_TX_LOAD;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              cfg_we_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  input  logic              rx_rd_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_full_o,
  input  logic              tx_we_i,
  input  logic [BYTE_W-1:0] tx_wdata_i,
  output logic              tx_need_o,
  output logic              match_evt_o,
  output logic              busy_o,
  output logic              dir_tx_o,
  output logic              nack_o
);
  logic              slv_en;
  logic [ADDR_W-1:0] slv_addr;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rx_push, tx_pop, tx_stall, tx_full;
  logic [BYTE_W-1:0] rx_byte, tx_data;

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_slv_engine u_engine (
    .clk_i, .rst_ni,
    .slv_en_i(slv_en), .slv_addr_i(slv_addr), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .rx_full_i(rx_full_o), .tx_full_i(tx_full), .tx_data_i(tx_data),
    .rx_push_o(rx_push), .rx_byte_o(rx_byte),
    .tx_pop_o(tx_pop), .tx_stall_o(tx_stall),
    .sda_oe_o, .scl_oe_o, .busy_o, .dir_tx_o, .nack_o,
    .match_o(match_evt_o)
  );

  i2c_slv_bufs u_bufs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i,
    .slv_en_o(slv_en), .slv_addr_o(slv_addr),
    .rx_push_i(rx_push), .rx_byte_i(rx_byte), .rx_rd_i,
    .rx_data_o, .rx_full_o,
    .tx_we_i, .tx_wdata_i, .tx_pop_i(tx_pop), .tx_stall_i(tx_stall),
    .tx_data_o(tx_data), .tx_full_o(tx_full), .tx_need_o
  );
endmodule

// File: rtl/i2c_addr_slave_chk.sv
module i2c_addr_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic slv_en,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic rx_rd_i,
  input logic rx_full_o,
  input logic tx_we_i,
  input logic tx_need_o,
  input logic match_evt_o
);
  a_r2_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slv_en |=> !scl_oe_o && !sda_oe_o && !busy_o);

  a_r3_drive_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o || sda_oe_o) |-> busy_o);

  a_r4_match_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_evt_o |=> !match_evt_o);

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && rx_full_o) |=> !rx_full_o);

  a_r6_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && !rx_rd_i) |=> rx_full_o);

  a_r8_write_clears_need: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_we_i |=> !tx_need_o);
endmodule

bind i2c_addr_slave i2c_addr_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slv_en(slv_en),
  .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
  .rx_rd_i(rx_rd_i), .rx_full_o(rx_full_o),
  .tx_we_i(tx_we_i), .tx_need_o(tx_need_o), .match_evt_o(match_evt_o)
);

// File: tb/i2c_addr_slave_tb.sv
module i2c_addr_slave_tb;
  localparam int Q     = 10;
  localparam int LIMIT = 190000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl, sda, scl_oe_o, sda_oe_o;
  logic cfg_we_i = 1'b0, rx_rd_i = 1'b0, tx_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = '0, tx_wdata_i = '0, rx_data_o;
  logic rx_full_o, tx_need_o, match_evt_o, busy_o, dir_tx_o, nack_o;
  int unsigned total = 0, bad = 0, match_cnt = 0;
  logic [6:0] my_addr;
  logic my_en;

  always #5 clk = ~clk;
  assign scl = !(m_scl_low || scl_oe_o);
  assign sda = !(m_sda_low || sda_oe_o);

  i2c_addr_slave u_dut (
    .clk_i(clk), .rst_ni, .scl_i(scl), .sda_i(sda), .scl_oe_o, .sda_oe_o,
    .cfg_we_i, .cfg_wdata_i, .rx_rd_i, .rx_data_o, .rx_full_o,
    .tx_we_i, .tx_wdata_i, .tx_need_o, .match_evt_o, .busy_o, .dir_tx_o, .nack_o
  );

  always @(negedge clk) if (rst_ni && match_evt_o) match_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_ack(input logic [6:0] a);
    return my_en && (a == my_addr);
  endfunction

  task automatic clks(input int n); repeat (n) @(negedge clk); endtask
  task automatic wait_scl_high; while (scl !== 1'b1) @(negedge clk); endtask

  task automatic cpu_cfg(input logic en, input logic [6:0] a);
    my_en = en; my_addr = a;
    cfg_wdata_i = {en, a}; cfg_we_i = 1'b1; clks(1); cfg_we_i = 1'b0; clks(1);
  endtask
  task automatic cpu_rd; rx_rd_i = 1'b1; clks(1); rx_rd_i = 1'b0; clks(1); endtask
  task automatic cpu_wr(input logic [7:0] d);
    tx_wdata_i = d; tx_we_i = 1'b1; clks(1); tx_we_i = 1'b0;
  endtask

  task automatic bit_io(input logic b, output logic rb);
    m_sda_low = !b; clks(Q);
    m_scl_low = 1'b0; wait_scl_high; clks(Q);
    rb = sda; clks(Q);
    m_scl_low = 1'b1; clks(Q);
  endtask
  task automatic bus_start;
    m_sda_low = 1'b0; clks(Q);
    m_scl_low = 1'b0; wait_scl_high; clks(Q);
    m_sda_low = 1'b1; clks(Q);
    m_scl_low = 1'b1; clks(Q);
  endtask
  task automatic bus_stop;
    m_sda_low = 1'b1; clks(Q);
    m_scl_low = 1'b0; wait_scl_high; clks(Q);
    m_sda_low = 1'b0; clks(2*Q);
  endtask
  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_io(d[i], r);
    bit_io(1'b1, r);
    ack = !r;
  endtask
  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin bit_io(1'b1, r); d = {d[6:0], r}; end
    bit_io(!give_ack, r);
  endtask

  initial begin
    clks(LIMIT);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected<%0d cycles", LIMIT, LIMIT);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack, r;
    logic [7:0] d, b0, b1, b2;
    int unsigned m0;
    void'($urandom(32'd20240611));
    my_en = 1'b0; my_addr = '0;
    clks(3); rst_ni = 1'b1; clks(2);

    // R1 reset state
    chk("R1", {scl_oe_o, sda_oe_o, busy_o, rx_full_o, tx_need_o, nack_o, match_evt_o},
        7'b0, "reset outputs");

    // R2 disabled port ignores its own address
    cpu_cfg(1'b0, 7'h52);
    bus_start;
    chk("R2", busy_o, 1'b0, "busy while disabled");
    wr_byte({7'h52, 1'b0}, ack);
    chk("R2", ack, 1'b0, "ack while disabled");
    bus_stop;

    // R3 R4 R5 R6 matched write
    cpu_cfg(1'b1, 7'h52);
    m0 = match_cnt;
    bus_start;
    chk("R3", busy_o, 1'b1, "busy after start");
    wr_byte({7'h52, 1'b0}, ack);
    chk("R4", ack, 1'b1, "ack on match");
    chk("R4", match_cnt - m0, 1, "match pulses");
    chk("R5", dir_tx_o, 1'b0, "dir on write");
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      wr_byte(d, ack);
      chk("R6", ack, 1'b1, "data ack");
      chk("R6", {rx_full_o, rx_data_o}, {1'b1, d}, "rx byte");
      cpu_rd;
      chk("R6", rx_full_o, 1'b0, "rx_full after read");
    end
    bus_stop;
    chk("R3", busy_o, 1'b0, "busy after stop");

    // R4 mismatch: no ack, data ignored
    m0 = match_cnt;
    bus_start;
    wr_byte({7'h53, 1'b0}, ack);
    chk("R4", ack, 1'b0, "ack on mismatch");
    wr_byte(8'h3c, ack);
    chk("R4", {ack, rx_full_o}, 2'b00, "data after mismatch");
    chk("R4", match_cnt - m0, 0, "no match pulse");
    bus_stop;

    // R7 receive stretch
    b0 = 8'hA5; b1 = 8'h5A;
    bus_start;
    wr_byte({7'h52, 1'b0}, ack);
    wr_byte(b0, ack);
    chk("R7", {ack, rx_data_o}, {1'b1, b0}, "first byte");
    fork
      wr_byte(b1, ack);
      begin
        for (int w = 0; w < 600 && !scl_oe_o; w++) clks(1);
        chk("R7", scl_oe_o, 1'b1, "scl held while rx full");
        clks(50);
        chk("R7", {scl_oe_o, rx_data_o}, {1'b1, b0}, "still held, old byte kept");
        cpu_rd;
      end
    join
    chk("R7", {ack, rx_full_o, rx_data_o}, {2'b11, b1}, "second byte after read");
    cpu_rd;
    bus_stop;

    // R8 R9 R10 R5 transmit
    b0 = 8'($urandom); b1 = 8'($urandom);
    cpu_wr(b0); clks(1);
    bus_start;
    wr_byte({7'h52, 1'b1}, ack);
    chk("R5", {ack, dir_tx_o}, 2'b11, "ack and dir on read");
    chk("R8", tx_need_o, 1'b1, "need after take");
    rd_byte(1'b1, d);
    chk("R8", d, b0, "first sent byte");
    chk("R9", {scl_oe_o, tx_need_o}, 2'b11, "held with empty buffer");
    clks(40);
    chk("R9", scl_oe_o, 1'b1, "still held");
    cpu_wr(b1);
    chk("R8", tx_need_o, 1'b0, "need cleared by write");
    rd_byte(1'b0, d);
    chk("R8", d, b1, "second sent byte");
    chk("R10", {nack_o, sda_oe_o}, 2'b10, "nack seen, sda released");
    bit_io(1'b1, r);
    chk("R10", r, 1'b1, "no drive after nack");
    bus_stop;

    // R11 repeated start, write then read
    b2 = 8'hC3;
    m0 = match_cnt;
    bus_start;
    wr_byte({7'h52, 1'b0}, ack);
    wr_byte(8'h81, ack);
    chk("R11", {rx_full_o, rx_data_o}, {1'b1, 8'h81}, "byte before restart");
    cpu_rd;
    cpu_wr(b2);
    bus_start;
    chk("R11", busy_o, 1'b1, "busy across restart");
    wr_byte({7'h52, 1'b1}, ack);
    chk("R11", {ack, dir_tx_o, nack_o}, 3'b110, "read after restart");
    rd_byte(1'b0, d);
    chk("R11", d, b2, "byte after restart");
    chk("R11", match_cnt - m0, 2, "two matches");
    bus_stop;

    // random mix
    cpu_cfg(1'b1, 7'($urandom));
    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      logic dir;
      int len;
      a   = ($urandom % 2) ? my_addr : 7'($urandom);
      dir = 1'($urandom);
      len = 1 + ($urandom % 3);
      if (dir) begin d = 8'($urandom); cpu_wr(d); end
      bus_start;
      wr_byte({a, dir}, ack);
      chk("R4", ack, exp_ack(a), "random addr ack");
      if (exp_ack(a)) chk("R10", {dir_tx_o, nack_o}, {dir, 1'b0}, "dir, nack cleared");
      for (int k = 0; k < len; k++) begin
        if (!dir) begin
          b0 = 8'($urandom);
          wr_byte(b0, ack);
          chk("R6", {ack, rx_full_o}, {2{exp_ack(a)}}, "random rx ack/full");
          if (exp_ack(a)) begin
            chk("R6", rx_data_o, b0, "random rx data");
            cpu_rd;
          end
        end else begin
          rd_byte(k != len - 1, b0);
          if (exp_ack(a)) begin
            chk("R8", b0, d, "random tx data");
            if (k != len - 1) begin d = 8'($urandom); cpu_wr(d); end
          end
        end
      end
      if (dir && exp_ack(a)) chk("R10", nack_o, 1'b1, "nack after last");
      bus_stop;
      chk("R3", busy_o, 1'b0, "random busy after stop");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule